// File: doc/BRIEF.md
# Audio Elastic Sample Buffer with Silence Recentering

This block sits between an audio receiver whose word clock is recovered from the incoming stream and a converter output paced by a fixed, low-jitter local clock. Words are stored on the source side. They are taken out on the local side each time the output asks for a sample. The two rates match only on average, so a small frequency error makes the amount of stored data creep up or down for as long as playback runs.

The buffer does not wait for that drift to reach a limit. Whenever the mute input is raised, the read side drops into a recentering state and the output is held at zero. Any surplus above half depth is drained at one word per read clock. If the buffer holds less than half depth, it waits for the writer to refill it. Output resumes only once the read side sees exactly half depth.

Two watermark flags on the write side let the sender be throttled. If all of this fails, the last-resort guards act: a word arriving into a full buffer is discarded, and a read from an empty buffer repeats the previous sample so the output never stalls. Both events are counted in saturating counters.

Top module: `audio_elastic_buf`

## Requirements
- R1: While reset is held and after its release, `rd_data_o` is zero, both event counters are zero, `repeat_o` and `drop_o` are low, and the read side starts in the recentering state.
- R2: Outside recentering, each `rd_en_i` with data available updates `rd_data_o` on the next read clock edge to the oldest stored word that has not been read or drained, in write order.
- R3: A write while the write-side fill equals the depth is discarded, the stored contents are unchanged, and `drop_o` pulses for one write clock on the next edge.
- R4: A read request outside recentering while the read-side fill is zero leaves `rd_data_o` unchanged and pulses `repeat_o` for one read clock on the next edge.
- R5: While `mute_i` is high or the read side is recentering, `rd_data_o` is driven to zero on the next read clock edge and no word is consumed by `rd_en_i`.
- R6: Raising `mute_i` puts the read side into recentering. While recentering, one word per read clock is discarded as long as the read-side fill exceeds half depth, and nothing is consumed below half depth. Recentering ends once `mute_i` is low and the read-side fill equals half depth.
- R7: `hi_water_o` is high exactly when the write-side fill is at or above `hi_mark_i`.
- R8: `lo_water_o` is high exactly when the write-side fill is at or below `lo_mark_i`.
- R9: `drop_cnt_o` and `repeat_cnt_o` count their events, never decrease, and hold at all ones.
- R10: A pointer change on either side reaches the other side's fill two clocks of the receiving domain later, through a Gray-coded two-flop synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_w_i | input | 1 | Source-side (recovered) clock |
| clk_r_i | input | 1 | Local output clock |
| rst_ni | input | 1 | Active-low asynchronous reset, both domains |
| wr_valid_i | input | 1 | Incoming word strobe, write domain |
| wr_data_i | input | DW | Incoming sample |
| hi_mark_i | input | AW+1 | High watermark threshold |
| lo_mark_i | input | AW+1 | Low watermark threshold |
| hi_water_o | output | 1 | Fill at or above high mark (hold off sender) |
| lo_water_o | output | 1 | Fill at or below low mark (resume sender) |
| drop_o | output | 1 | One-cycle pulse: word discarded at full |
| drop_cnt_o | output | CW | Saturating discard counter |
| rd_en_i | input | 1 | Sample request, read domain |
| mute_i | input | 1 | Silence indication, read domain |
| rd_data_o | output | DW | Output sample |
| repeat_o | output | 1 | One-cycle pulse: sample repeated at empty |
| repeat_cnt_o | output | CW | Saturating repeat counter |

## Verification
A wrong pointer or a wrong synchronizer delay shows up as shifted watermark flags and `drop_o` pulses. These appear within a few write clocks of the first burst that nears full. A stuck or misrouted read pointer gives an output word out of sequence on the very next request. A recentering state that ends at the wrong fill shows as the first sample after mute coming from the wrong index, one clock after play resumes. Saturation faults in the counters become visible only after fifteen or more events, so the bench uses a narrow counter width and drives long overrun and underrun stretches.

// File: rtl/elbuf_pkg.sv
package elbuf_pkg;
  typedef enum logic {
    RD_CENTER = 1'b0,
    RD_PLAY   = 1'b1
  } rd_state_e;
endpackage

// File: rtl/elbuf_ptr_cdc.sv
module elbuf_ptr_cdc #(
  parameter int PW = 5
) (
  input  logic          clk_s_i,
  input  logic          clk_d_i,
  input  logic          rst_ni,
  input  logic [PW-1:0] ptr_nxt_i,
  output logic [PW-1:0] ptr_o
);
  logic [PW-1:0] gray_q, s1_q, s2_q;
  logic [PW-1:0] bin;

  // gray register tracks the registered pointer in the same cycle
  always_ff @(posedge clk_s_i or negedge rst_ni) begin
    if (!rst_ni) gray_q <= '0;
    else         gray_q <= ptr_nxt_i ^ (ptr_nxt_i >> 1);
  end

  always_ff @(posedge clk_d_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= gray_q;
      s2_q <= s1_q;
    end
  end

  always_comb begin
    bin[PW-1] = s2_q[PW-1];
    for (int i = PW - 2; i >= 0; i--) bin[i] = bin[i+1] ^ s2_q[i];
  end

  assign ptr_o = bin;
endmodule

// File: rtl/elbuf_sat_cnt.sv
module elbuf_sat_cnt #(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          inc_i,
  output logic [CW-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_o <= '0;
    else if (inc_i && cnt_o != '1) cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/elbuf_wr_side.sv
module elbuf_wr_side #(
  parameter int AW = 4,
  parameter int DW = 16,
  parameter int CW = 16,
  localparam int PW = AW + 1,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [DW-1:0] data_i,
  input  logic [PW-1:0] rptr_sync_i,
  input  logic [PW-1:0] hi_mark_i,
  input  logic [PW-1:0] lo_mark_i,
  output logic [PW-1:0] wptr_nxt_o,
  output logic [PW-1:0] fill_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_data_o,
  output logic          hi_o,
  output logic          lo_o,
  output logic          drop_o,
  output logic [CW-1:0] drop_cnt_o
);
  localparam logic [PW-1:0] FULL = PW'(DEPTH);

  logic [PW-1:0] wptr_q;
  logic          full, accept, drop_ev;

  assign fill_o     = wptr_q - rptr_sync_i;
  assign full       = (fill_o == FULL);
  assign accept     = valid_i && !full;
  assign drop_ev    = valid_i && full;
  assign wptr_nxt_o = wptr_q + PW'(accept);
  assign mem_we_o   = accept;
  assign mem_addr_o = wptr_q[AW-1:0];
  assign mem_data_o = data_i;
  assign hi_o       = (fill_o >= hi_mark_i);
  assign lo_o       = (fill_o <= lo_mark_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      drop_o <= 1'b0;
    end else begin
      wptr_q <= wptr_nxt_o;
      drop_o <= drop_ev;
    end
  end

  elbuf_sat_cnt #(.CW(CW)) i_drop_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .inc_i (drop_ev),
    .cnt_o (drop_cnt_o)
  );
endmodule

// File: rtl/elbuf_rd_side.sv
module elbuf_rd_side
  import elbuf_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 16,
  parameter int CW = 16,
  localparam int PW = AW + 1,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_en_i,
  input  logic          mute_i,
  input  logic [PW-1:0] wptr_sync_i,
  input  logic [DW-1:0] mem_data_i,
  output logic [AW-1:0] mem_addr_o,
  output logic [PW-1:0] rptr_nxt_o,
  output logic [PW-1:0] fill_o,
  output logic          center_o,
  output logic [DW-1:0] data_o,
  output logic          rep_o,
  output logic [CW-1:0] rep_cnt_o
);
  localparam logic [PW-1:0] HALF = PW'(DEPTH / 2);

  rd_state_e     state_q, state_d;
  logic [PW-1:0] rptr_q;
  logic          drain, take, rep_ev, quiet;

  assign fill_o     = wptr_sync_i - rptr_q;
  assign center_o   = (state_q == RD_CENTER);
  assign quiet      = center_o || mute_i;
  assign drain      = center_o && (fill_o > HALF);
  assign take       = !quiet && rd_en_i && (fill_o != '0);
  assign rep_ev     = !quiet && rd_en_i && (fill_o == '0);
  assign rptr_nxt_o = rptr_q + PW'(drain || take);
  assign mem_addr_o = rptr_q[AW-1:0];

  always_comb begin
    state_d = state_q;
    if (mute_i)                             state_d = RD_CENTER;
    else if (center_o && (fill_o == HALF))  state_d = RD_PLAY;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RD_CENTER;
      rptr_q  <= '0;
      data_o  <= '0;
      rep_o   <= 1'b0;
    end else begin
      state_q <= state_d;
      rptr_q  <= rptr_nxt_o;
      rep_o   <= rep_ev;
      if (quiet)     data_o <= '0;
      else if (take) data_o <= mem_data_i;
    end
  end

  elbuf_sat_cnt #(.CW(CW)) i_rep_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .inc_i (rep_ev),
    .cnt_o (rep_cnt_o)
  );
endmodule

// File: rtl/audio_elastic_buf.sv
module audio_elastic_buf #(
  parameter int AW = 4,
  parameter int DW = 16,
  parameter int CW = 16,
  localparam int PW = AW + 1,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk_w_i,
  input  logic          clk_r_i,
  input  logic          rst_ni,
  input  logic          wr_valid_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [PW-1:0] hi_mark_i,
  input  logic [PW-1:0] lo_mark_i,
  output logic          hi_water_o,
  output logic          lo_water_o,
  output logic          drop_o,
  output logic [CW-1:0] drop_cnt_o,
  input  logic          rd_en_i,
  input  logic          mute_i,
  output logic [DW-1:0] rd_data_o,
  output logic          repeat_o,
  output logic [CW-1:0] repeat_cnt_o
);
  logic [PW-1:0] wptr_nxt, rptr_nxt, wptr_sync, rptr_sync;
  logic [PW-1:0] wr_fill, rd_fill;
  logic          mem_we, rd_center;
  logic [AW-1:0] waddr, raddr;
  logic [DW-1:0] wdata, rword;
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_w_i) begin
    if (mem_we) mem_q[waddr] <= wdata;
  end
  assign rword = mem_q[raddr];

  elbuf_wr_side #(.AW(AW), .DW(DW), .CW(CW)) i_wr (
    .clk_i      (clk_w_i),
    .rst_ni     (rst_ni),
    .valid_i    (wr_valid_i),
    .data_i     (wr_data_i),
    .rptr_sync_i(rptr_sync),
    .hi_mark_i  (hi_mark_i),
    .lo_mark_i  (lo_mark_i),
    .wptr_nxt_o (wptr_nxt),
    .fill_o     (wr_fill),
    .mem_we_o   (mem_we),
    .mem_addr_o (waddr),
    .mem_data_o (wdata),
    .hi_o       (hi_water_o),
    .lo_o       (lo_water_o),
    .drop_o     (drop_o),
    .drop_cnt_o (drop_cnt_o)
  );

  elbuf_rd_side #(.AW(AW), .DW(DW), .CW(CW)) i_rd (
    .clk_i      (clk_r_i),
    .rst_ni     (rst_ni),
    .rd_en_i    (rd_en_i),
    .mute_i     (mute_i),
    .wptr_sync_i(wptr_sync),
    .mem_data_i (rword),
    .mem_addr_o (raddr),
    .rptr_nxt_o (rptr_nxt),
    .fill_o     (rd_fill),
    .center_o   (rd_center),
    .data_o     (rd_data_o),
    .rep_o      (repeat_o),
    .rep_cnt_o  (repeat_cnt_o)
  );

  elbuf_ptr_cdc #(.PW(PW)) i_w2r (
    .clk_s_i  (clk_w_i),
    .clk_d_i  (clk_r_i),
    .rst_ni   (rst_ni),
    .ptr_nxt_i(wptr_nxt),
    .ptr_o    (wptr_sync)
  );

  elbuf_ptr_cdc #(.PW(PW)) i_r2w (
    .clk_s_i  (clk_r_i),
    .clk_d_i  (clk_w_i),
    .rst_ni   (rst_ni),
    .ptr_nxt_i(rptr_nxt),
    .ptr_o    (rptr_sync)
  );
endmodule

// File: rtl/elbuf_checker.sv
module elbuf_checker #(
  parameter int AW = 4,
  parameter int DW = 16,
  parameter int CW = 16,
  localparam int PW = AW + 1,
  localparam int DEPTH = 1 << AW
) (
  input logic          clk_w_i,
  input logic          clk_r_i,
  input logic          rst_ni,
  input logic          wr_valid_i,
  input logic          drop_o,
  input logic [CW-1:0] drop_cnt_o,
  input logic          rd_en_i,
  input logic          mute_i,
  input logic [DW-1:0] rd_data_o,
  input logic          repeat_o,
  input logic [CW-1:0] repeat_cnt_o,
  input logic [PW-1:0] wr_fill,
  input logic [PW-1:0] rd_fill,
  input logic          rd_center
);
  localparam logic [PW-1:0] HALF = PW'(DEPTH / 2);

  assert_fill_bound_R3: assert property (@(posedge clk_w_i) disable iff (!rst_ni)
    wr_fill <= PW'(DEPTH));

  assert_drop_needs_write_R3: assert property (@(posedge clk_w_i) disable iff (!rst_ni)
    drop_o |-> $past(wr_valid_i));

  assert_repeat_holds_R4: assert property (@(posedge clk_r_i) disable iff (!rst_ni)
    repeat_o |-> $stable(rd_data_o));

  assert_mute_silent_R5: assert property (@(posedge clk_r_i) disable iff (!rst_ni)
    mute_i |=> (rd_data_o == '0));

  assert_center_no_repeat_R5: assert property (@(posedge clk_r_i) disable iff (!rst_ni)
    rd_center |=> !repeat_o);

  assert_no_read_below_half_R6: assert property (@(posedge clk_r_i) disable iff (!rst_ni)
    (rd_center && rd_fill < HALF) |=> (rd_fill >= $past(rd_fill)));

  assert_drop_cnt_mono_R9: assert property (@(posedge clk_w_i) disable iff (!rst_ni)
    drop_cnt_o >= $past(drop_cnt_o));

  assert_rep_cnt_mono_R9: assert property (@(posedge clk_r_i) disable iff (!rst_ni)
    repeat_cnt_o >= $past(repeat_cnt_o));
endmodule

bind audio_elastic_buf elbuf_checker #(.AW(AW), .DW(DW), .CW(CW)) i_elbuf_checker (
  .clk_w_i     (clk_w_i),
  .clk_r_i     (clk_r_i),
  .rst_ni      (rst_ni),
  .wr_valid_i  (wr_valid_i),
  .drop_o      (drop_o),
  .drop_cnt_o  (drop_cnt_o),
  .rd_en_i     (rd_en_i),
  .mute_i      (mute_i),
  .rd_data_o   (rd_data_o),
  .repeat_o    (repeat_o),
  .repeat_cnt_o(repeat_cnt_o),
  .wr_fill     (wr_fill),
  .rd_fill     (rd_fill),
  .rd_center   (rd_center)
);

// File: tb/test_audio_elastic_buf.sv
module test_audio_elastic_buf;
  localparam int AW = 4;
  localparam int DW = 16;
  localparam int CW = 4;
  localparam int PW = AW + 1;
  localparam int DEPTH = 1 << AW;
  localparam int HALF = DEPTH / 2;
  localparam int CMAX = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_valid = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [PW-1:0] hi_mark = PW'(12);
  logic [PW-1:0] lo_mark = PW'(4);
  logic          hi_water, lo_water, drop, rep;
  logic [CW-1:0] drop_cnt, rep_cnt;
  logic          rd_en = 1'b0;
  logic          mute = 1'b0;
  logic [DW-1:0] rd_data;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  audio_elastic_buf #(.AW(AW), .DW(DW), .CW(CW)) i_audio_elastic_buf (
    .clk_w_i     (clk),
    .clk_r_i     (clk),
    .rst_ni      (rst_n),
    .wr_valid_i  (wr_valid),
    .wr_data_i   (wr_data),
    .hi_mark_i   (hi_mark),
    .lo_mark_i   (lo_mark),
    .hi_water_o  (hi_water),
    .lo_water_o  (lo_water),
    .drop_o      (drop),
    .drop_cnt_o  (drop_cnt),
    .rd_en_i     (rd_en),
    .mute_i      (mute),
    .rd_data_o   (rd_data),
    .repeat_o    (rep),
    .repeat_cnt_o(rep_cnt)
  );

  // behavioural reference: unbounded counts, store keyed by absolute index
  logic [DW-1:0] store [int];
  int  m_wp, m_rp, wp_h1, wp_h2, rp_h1, rp_h2;
  bit  m_center, m_drop, m_rep;
  int  m_drop_cnt, m_rep_cnt, m_play;
  logic [DW-1:0] m_dout;
  string m_tag;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_wp = 0; m_rp = 0; wp_h1 = 0; wp_h2 = 0; rp_h1 = 0; rp_h2 = 0;
      m_center = 1'b1; m_drop = 1'b0; m_rep = 1'b0;
      m_drop_cnt = 0; m_rep_cnt = 0; m_play = 0;
      m_dout = '0; m_tag = "R1";
    end else begin
      int wfill, rfill, nwp, nrp;
      bit ncenter;
      wfill = m_wp - rp_h2;
      rfill = wp_h2 - m_rp;
      nwp = m_wp;
      nrp = m_rp;
      m_drop = wr_valid && (wfill >= DEPTH);
      if (m_drop && m_drop_cnt < CMAX) m_drop_cnt++;
      if (wr_valid && wfill < DEPTH) begin
        store[m_wp] = wr_data;
        nwp = m_wp + 1;
      end
      ncenter = mute ? 1'b1 : ((m_center && rfill == HALF) ? 1'b0 : m_center);
      m_rep = 1'b0;
      if (m_center && rfill > HALF) nrp = m_rp + 1;
      if (m_center || mute) begin
        m_dout = '0;
        m_tag = "R5";
      end else if (rd_en) begin
        if (rfill == 0) begin
          m_rep = 1'b1;
          if (m_rep_cnt < CMAX) m_rep_cnt++;
          m_tag = "R4";
        end else begin
          m_dout = store[m_rp];
          nrp = m_rp + 1;
          m_tag = (m_play < 4) ? "R6" : "R2";
        end
      end
      m_play = m_center ? 0 : m_play + 1;
      m_center = ncenter;
      wp_h2 = wp_h1; wp_h1 = m_wp; m_wp = nwp;
      rp_h2 = rp_h1; rp_h1 = m_rp; m_rp = nrp;
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(m_tag, "rd_data", 32'(rd_data), 32'(m_dout));
      chk("R3", "drop", 32'(drop), 32'(m_drop));
      chk("R4", "repeat", 32'(rep), 32'(m_rep));
      chk("R7", "hi_water", 32'(hi_water), 32'((m_wp - rp_h2) >= int'(hi_mark)));
      chk("R8", "lo_water", 32'(lo_water), 32'((m_wp - rp_h2) <= int'(lo_mark)));
      chk("R9", "drop_cnt", 32'(drop_cnt), 32'(m_drop_cnt));
      chk("R9", "repeat_cnt", 32'(rep_cnt), 32'(m_rep_cnt));
    end
  end

  task automatic step(input bit wv, input bit re, input bit mu);
    @(negedge clk);
    wr_valid = wv;
    rd_en = re;
    mute = mu;
    if (wv) wr_data = wr_data + 16'h0101;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1", "rd_data", 32'(rd_data), 32'h0);
    chk("R1", "drop_cnt", 32'(drop_cnt), 32'h0);
    chk("R1", "repeat_cnt", 32'(rep_cnt), 32'h0);
    chk("R1", "repeat", 32'(rep), 32'h0);
    chk("R1", "drop", 32'(drop), 32'h0);
    chk("R8", "lo_water", 32'(lo_water), 32'h1);
    rst_n = 1'b1;
    // R1/R6: start-up fill to half, then balanced play (R2, R10)
    for (int i = 0; i < 40; i++) step(1'b1, 1'b1, 1'b0);
    // R3/R7/R9: writer faster than reader, overruns past counter saturation
    for (int i = 0; i < 90; i++) step(1'b1, i[0], 1'b0);
    // R5/R6: mute with surplus, drain to half, resume
    for (int i = 0; i < 12; i++) step(i[0], 1'b1, 1'b1);
    for (int i = 0; i < 30; i++) step(1'b1, 1'b1, 1'b0);
    // R4/R8/R9: writer stops, underruns past counter saturation
    for (int i = 0; i < 50; i++) step(1'b0, 1'b1, 1'b0);
    // R6: mute while empty, refill to half before play, slow writer
    for (int i = 0; i < 4; i++) step(1'b0, 1'b1, 1'b1);
    for (int i = 0; i < 80; i++) step(i % 3 == 0, 1'b1, 1'b0);
    // R2: alternating patterns after a short mute
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 1'b1);
    for (int i = 0; i < 60; i++) step(1'b1, i % 4 != 0, 1'b0);
    step(1'b0, 1'b0, 1'b0);
    @(negedge clk);
    finish_run();
  end
endmodule